// File: doc/BRIEF.md
# Per-Thread Squash Controller

This block decides, for every hardware thread, when the reorder buffer must be squashed and tells the earlier pipeline stages about it. Each thread has a small state machine and a register that holds the youngest sequence number still live in the buffer. Three kinds of request can start a squash. The first is a redirect from execute, which carries a sequence number, an include-self bit, a restart PC and the mispredict and taken bits. The second is a trap, which fires a fixed number of cycles after a fault is reported. The third is a thread-context squash.

A redirect from execute is kept only when it is no younger than the youngest live instruction and the thread is not waiting on a trap. This stops a late squash from a younger instruction from overriding an older one. A trap squash or a thread-context squash clears the whole thread back to one before the buffer head. Once a squash starts, the thread stays in its squashing state until the buffer reports that its walk has finished. While the thread is squashing, new instructions from rename are refused. All feedback is registered: it appears in the cycle after the decision and lasts one cycle. The one exception is the squash-in-progress indication, which is repeated every cycle until the walk is done.

Per-thread states are: `TS_RUN` (0, normal), `TS_TRAP_WAIT` (1, trap latency running) and `TS_SQUASH` (2, buffer walk in progress). The transitions are:
- run→trap-wait, on a trap request while running.
- any→squash, on an accepted squash of any kind.
- squash→run, when the buffer reports the walk done.

Top module: `squash_ctrl`

## Requirements
- R1: After reset every thread is in `TS_RUN` (encoding 0; 1 is `TS_TRAP_WAIT`, 2 is `TS_SQUASH`, 3 is never used). All feedback and command outputs are 0, the mispredict count is 0, and the youngest sequence number is 0.
- R2: A redirect from execute is accepted when the thread is not in `TS_TRAP_WAIT` and its sequence number is ≤ the thread's youngest sequence number. In the following cycle the block raises `rob_sq_valid`, `fb_squash` and `fb_rob_sq` for that thread. It also drives the target on `rob_sq_seq` and `fb_done_seq`, and copies the redirect PC, the mispredict bit and the taken bit to the feedback.
- R3: A redirect whose sequence number is greater than the youngest sequence number has no effect: no squash output and no state change.
- R4: With the include-self bit set, the target is the reported sequence number minus one. After any accepted redirect, the youngest sequence number equals the target.
- R5: A thread in `TS_SQUASH` leaves for `TS_RUN` only in a cycle where `rob_done_sq` is high. In every cycle after one spent in `TS_SQUASH` without done, `fb_rob_sq` is high while `fb_squash` stays low.
- R6: An insert is passed on (`rob_ins_en`, combinational) only when the thread does not start a squash in that cycle and is not in `TS_SQUASH`. A thread finishing its walk in that same cycle counts as not squashing. Each accepted insert makes its sequence number the thread's youngest.
- R7: A trap request sampled at clock edge E puts the thread in `TS_TRAP_WAIT` after E. The trap squash appears on the outputs after edge E+TRAP_LAT+1 and not before. Redirects from execute are ignored while the thread is in `TS_TRAP_WAIT`.
- R8: A trap or thread-context squash targets the head sequence number minus one, or 0 when the buffer is empty. It resets the youngest sequence number to 0, drives `fb_mispred` and `fb_taken` low, and returns `arch_pc` as the restart PC. It takes precedence over a redirect from execute in the same cycle.
- R9: When a trap squash and a thread-context request meet in one cycle, only the trap squash is performed. `conflict_err` for that thread is high for one cycle with it.
- R10: `mispred_cnt` grows by the number of threads whose accepted redirect from execute carried the mispredict bit. It changes in the same cycle as the feedback.
- R11: Threads are independent: a request on one thread never changes the outputs or state of another.
- R12: Apart from `fb_rob_sq` under R5, every feedback and command output is high, or non-zero, for exactly one cycle per squash and is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ex_sq_valid | input | N_THR | Redirect from execute, per thread |
| ex_sq_seq | input | N_THR×SEQ_W | Sequence number of the redirecting instruction |
| ex_sq_incl | input | N_THR | Include the redirecting instruction in the squash |
| ex_sq_pc | input | N_THR×PC_W | Restart PC from execute |
| ex_sq_mispred | input | N_THR | Redirect is a branch mispredict |
| ex_sq_taken | input | N_THR | Branch outcome was taken |
| trap_req | input | N_THR | Fault reported at commit, starts the trap latency |
| ctx_sq_req | input | N_THR | Thread-context squash request |
| arch_pc | input | N_THR×PC_W | Committed PC used as restart for trap and context squashes |
| rob_empty | input | N_THR | Buffer holds no entry of this thread |
| rob_head_seq | input | N_THR×SEQ_W | Sequence number at the buffer head |
| rob_done_sq | input | N_THR | Buffer finished its squash walk |
| ins_valid | input | N_THR | Renamed instruction offered for insertion |
| ins_seq | input | N_THR×SEQ_W | Its sequence number |
| rob_ins_en | output | N_THR | Insert accepted (combinational) |
| rob_sq_valid | output | N_THR | Squash command to the buffer |
| rob_sq_seq | output | N_THR×SEQ_W | Squash everything younger than this |
| fb_squash | output | N_THR | Feedback: squash now |
| fb_rob_sq | output | N_THR | Feedback: buffer squash in progress |
| fb_done_seq | output | N_THR×SEQ_W | Feedback: squash target sequence number |
| fb_mispred | output | N_THR | Feedback: mispredict |
| fb_taken | output | N_THR | Feedback: branch taken |
| fb_next_pc | output | N_THR×PC_W | Feedback: restart PC |
| thr_state | output | N_THR×2 | Per-thread state encoding |
| conflict_err | output | N_THR | Trap and context squash collided |
| mispred_cnt | output | CNT_W | Accepted mispredict count |

## Verification
The bench first offers a redirect younger than the youngest live instruction. A design that skipped the age filter would squash on it. It then repeats a redirect one above an include-self target, which a design that did not subtract one would accept. On the trap path it checks the exact cycle of the squash and sends a mispredicting redirect into the firing cycle. A latency off by one would show the squash early or late, and a wrong priority would leak the mispredict into the feedback or the count. It also offers an insert in the very cycle a walk finishes, and a context request in the cycle a trap fires. A design that read the old state there would refuse the insert, and one with the wrong priority would perform a second squash.

// File: rtl/sqc_pkg.sv
package sqc_pkg;
    typedef enum logic [1:0] {
        TS_RUN       = 2'd0,
        TS_TRAP_WAIT = 2'd1,
        TS_SQUASH    = 2'd2
    } thr_state_e;
endpackage

// File: rtl/sqc_trap_timer.sv
module sqc_trap_timer #(
    parameter int LAT = 4,
    localparam int CW = $clog2(LAT + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    output logic idle,
    output logic fire
);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt  <= '0;
            fire <= 1'b0;
        end else begin
            fire <= (cnt == CW'(1));
            if (cnt != '0)
                cnt <= cnt - CW'(1);
            else if (arm)
                cnt <= CW'(LAT);
        end
    end

    assign idle = (cnt == '0) && !fire;
endmodule

// File: rtl/sqc_thread.sv
module sqc_thread
    import sqc_pkg::*;
#(
    parameter int SEQ_W = 16,
    parameter int PC_W  = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ex_vld,
    input  logic [SEQ_W-1:0] ex_seq,
    input  logic             ex_incl,
    input  logic [PC_W-1:0]  ex_pc,
    input  logic             ex_mis,
    input  logic             ex_tkn,
    input  logic             trap_req,
    input  logic             trap_idle,
    input  logic             trap_fire,
    input  logic             ctx_req,
    input  logic [PC_W-1:0]  arch_pc,
    input  logic             rob_empty,
    input  logic [SEQ_W-1:0] head_seq,
    input  logic             done_sq,
    input  logic             ins_vld,
    input  logic [SEQ_W-1:0] ins_seq,
    output logic             trap_arm,
    output logic             ins_en,
    output logic             mis_evt,
    output logic [1:0]       state_o,
    output logic             sq_vld,
    output logic [SEQ_W-1:0] sq_seq,
    output logic             fb_sq,
    output logic             fb_rob_sq,
    output logic [SEQ_W-1:0] fb_seq,
    output logic             fb_mis,
    output logic             fb_tkn,
    output logic [PC_W-1:0]  fb_pc,
    output logic             conflict
);
    thr_state_e       st, st_mid, st_nx;
    logic [SEQ_W-1:0] youngest, youngest_nx;
    logic [SEQ_W-1:0] whole_tgt, ex_tgt, tgt;
    logic             whole_sq, trap_sq, ctx_sq, ex_ok, any_sq, still_sq;
    logic [PC_W-1:0]  restart_pc;

    // Squash selection and next state
    always_comb begin
        unique case (st)
            TS_RUN:       st_mid = TS_RUN;
            TS_TRAP_WAIT: st_mid = TS_TRAP_WAIT;
            TS_SQUASH:    st_mid = done_sq ? TS_RUN : TS_SQUASH;
            default:      st_mid = TS_RUN;
        endcase

        still_sq  = (st == TS_SQUASH) && !done_sq;
        trap_sq   = trap_fire;
        ctx_sq    = ctx_req && !trap_fire;
        whole_sq  = trap_sq || ctx_sq;
        whole_tgt = rob_empty ? '0 : head_seq - SEQ_W'(1);
        ex_tgt    = ex_incl ? ex_seq - SEQ_W'(1) : ex_seq;
        ex_ok     = ex_vld && !whole_sq && (st_mid != TS_TRAP_WAIT)
                    && (ex_seq <= youngest);
        any_sq    = whole_sq || ex_ok;
        ins_en    = ins_vld && !any_sq && (st_mid != TS_SQUASH);
        trap_arm  = trap_req && trap_idle;
        mis_evt   = ex_ok && ex_mis;

        tgt        = whole_sq ? whole_tgt : (ex_ok ? ex_tgt : '0);
        restart_pc = whole_sq ? arch_pc : (ex_ok ? ex_pc : '0);

        if (any_sq)
            st_nx = TS_SQUASH;
        else if (trap_arm && st_mid == TS_RUN)
            st_nx = TS_TRAP_WAIT;
        else
            st_nx = st_mid;

        if (whole_sq)
            youngest_nx = '0;
        else if (ex_ok)
            youngest_nx = ex_tgt;
        else if (ins_en)
            youngest_nx = ins_seq;
        else
            youngest_nx = youngest;
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= TS_RUN;
            youngest <= '0;
        end else begin
            st       <= st_nx;
            youngest <= youngest_nx;
        end
    end

    // Registered outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sq_vld    <= 1'b0;
            sq_seq    <= '0;
            fb_sq     <= 1'b0;
            fb_rob_sq <= 1'b0;
            fb_seq    <= '0;
            fb_mis    <= 1'b0;
            fb_tkn    <= 1'b0;
            fb_pc     <= '0;
            conflict  <= 1'b0;
        end else begin
            sq_vld    <= any_sq;
            sq_seq    <= tgt;
            fb_sq     <= any_sq;
            fb_rob_sq <= any_sq || still_sq;
            fb_seq    <= tgt;
            fb_mis    <= ex_ok && ex_mis;
            fb_tkn    <= ex_ok && ex_tkn;
            fb_pc     <= restart_pc;
            conflict  <= trap_fire && ctx_req;
        end
    end

    assign state_o = st;
endmodule

// File: rtl/sqc_event_cnt.sv
module sqc_event_cnt #(
    parameter int N = 2,
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] evt,
    output logic [W-1:0] cnt
);
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else
            cnt <= cnt + W'($countones(evt));
    end
endmodule

// File: rtl/squash_ctrl.sv
module squash_ctrl #(
    parameter int N_THR    = 2,
    parameter int SEQ_W    = 16,
    parameter int PC_W     = 32,
    parameter int TRAP_LAT = 4,
    parameter int CNT_W    = 16
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [N_THR-1:0]            ex_sq_valid,
    input  logic [N_THR-1:0][SEQ_W-1:0] ex_sq_seq,
    input  logic [N_THR-1:0]            ex_sq_incl,
    input  logic [N_THR-1:0][PC_W-1:0]  ex_sq_pc,
    input  logic [N_THR-1:0]            ex_sq_mispred,
    input  logic [N_THR-1:0]            ex_sq_taken,
    input  logic [N_THR-1:0]            trap_req,
    input  logic [N_THR-1:0]            ctx_sq_req,
    input  logic [N_THR-1:0][PC_W-1:0]  arch_pc,
    input  logic [N_THR-1:0]            rob_empty,
    input  logic [N_THR-1:0][SEQ_W-1:0] rob_head_seq,
    input  logic [N_THR-1:0]            rob_done_sq,
    input  logic [N_THR-1:0]            ins_valid,
    input  logic [N_THR-1:0][SEQ_W-1:0] ins_seq,
    output logic [N_THR-1:0]            rob_ins_en,
    output logic [N_THR-1:0]            rob_sq_valid,
    output logic [N_THR-1:0][SEQ_W-1:0] rob_sq_seq,
    output logic [N_THR-1:0]            fb_squash,
    output logic [N_THR-1:0]            fb_rob_sq,
    output logic [N_THR-1:0][SEQ_W-1:0] fb_done_seq,
    output logic [N_THR-1:0]            fb_mispred,
    output logic [N_THR-1:0]            fb_taken,
    output logic [N_THR-1:0][PC_W-1:0]  fb_next_pc,
    output logic [N_THR-1:0][1:0]       thr_state,
    output logic [N_THR-1:0]            conflict_err,
    output logic [CNT_W-1:0]            mispred_cnt
);
    logic [N_THR-1:0] trap_arm, trap_idle, trap_fire, mis_evt;

    for (genvar g = 0; g < N_THR; g++) begin : g_thr
        sqc_trap_timer #(.LAT(TRAP_LAT)) u_timer (
            .clk   (clk),
            .rst_n (rst_n),
            .arm   (trap_arm[g]),
            .idle  (trap_idle[g]),
            .fire  (trap_fire[g])
        );

        sqc_thread #(.SEQ_W(SEQ_W), .PC_W(PC_W)) u_thread (
            .clk       (clk),
            .rst_n     (rst_n),
            .ex_vld    (ex_sq_valid[g]),
            .ex_seq    (ex_sq_seq[g]),
            .ex_incl   (ex_sq_incl[g]),
            .ex_pc     (ex_sq_pc[g]),
            .ex_mis    (ex_sq_mispred[g]),
            .ex_tkn    (ex_sq_taken[g]),
            .trap_req  (trap_req[g]),
            .trap_idle (trap_idle[g]),
            .trap_fire (trap_fire[g]),
            .ctx_req   (ctx_sq_req[g]),
            .arch_pc   (arch_pc[g]),
            .rob_empty (rob_empty[g]),
            .head_seq  (rob_head_seq[g]),
            .done_sq   (rob_done_sq[g]),
            .ins_vld   (ins_valid[g]),
            .ins_seq   (ins_seq[g]),
            .trap_arm  (trap_arm[g]),
            .ins_en    (rob_ins_en[g]),
            .mis_evt   (mis_evt[g]),
            .state_o   (thr_state[g]),
            .sq_vld    (rob_sq_valid[g]),
            .sq_seq    (rob_sq_seq[g]),
            .fb_sq     (fb_squash[g]),
            .fb_rob_sq (fb_rob_sq[g]),
            .fb_seq    (fb_done_seq[g]),
            .fb_mis    (fb_mispred[g]),
            .fb_tkn    (fb_taken[g]),
            .fb_pc     (fb_next_pc[g]),
            .conflict  (conflict_err[g])
        );
    end

    sqc_event_cnt #(.N(N_THR), .W(CNT_W)) u_miscnt (
        .clk   (clk),
        .rst_n (rst_n),
        .evt   (mis_evt),
        .cnt   (mispred_cnt)
    );
endmodule

// File: rtl/sqc_checker.sv
module sqc_checker
    import sqc_pkg::*;
#(
    parameter int N_THR = 2,
    parameter int CNT_W = 16
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [N_THR-1:0]      rob_done_sq,
    input logic [N_THR-1:0]      rob_ins_en,
    input logic [N_THR-1:0]      fb_squash,
    input logic [N_THR-1:0]      fb_rob_sq,
    input logic [N_THR-1:0]      fb_mispred,
    input logic [N_THR-1:0][1:0] thr_state,
    input logic [CNT_W-1:0]      mispred_cnt
);
    for (genvar t = 0; t < N_THR; t++) begin : g_chk
        AST_STATE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n) thr_state[t] != 2'd3); // R1
        AST_SQ_WITH_ROBSQ: assert property (@(posedge clk) disable iff (!rst_n) fb_squash[t] |-> fb_rob_sq[t]); // R5
        AST_SQ_IN_STATE: assert property (@(posedge clk) disable iff (!rst_n) fb_squash[t] |-> thr_state[t] == TS_SQUASH); // R5
        AST_ROBSQ_PERSIST: assert property (@(posedge clk) disable iff (!rst_n) (thr_state[t] == TS_SQUASH && !rob_done_sq[t]) |=> fb_rob_sq[t]); // R5
        AST_NO_INS_SQUASH: assert property (@(posedge clk) disable iff (!rst_n) (thr_state[t] == TS_SQUASH && !rob_done_sq[t]) |-> !rob_ins_en[t]); // R6
        AST_MIS_NEEDS_SQ: assert property (@(posedge clk) disable iff (!rst_n) fb_mispred[t] |-> fb_squash[t]); // R10
        AST_TRAPWAIT_NO_EXEC: assert property (@(posedge clk) disable iff (!rst_n) fb_mispred[t] |-> $past(thr_state[t]) != TS_TRAP_WAIT); // R7
    end

    AST_CNT_TRACK: assert property (@(posedge clk) disable iff (!rst_n) mispred_cnt == $past(mispred_cnt) + CNT_W'($countones(fb_mispred))); // R10
endmodule

bind squash_ctrl sqc_checker #(.N_THR(N_THR), .CNT_W(CNT_W)) u_sqc_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .rob_done_sq (rob_done_sq),
    .rob_ins_en  (rob_ins_en),
    .fb_squash   (fb_squash),
    .fb_rob_sq   (fb_rob_sq),
    .fb_mispred  (fb_mispred),
    .thr_state   (thr_state),
    .mispred_cnt (mispred_cnt)
);

// File: tb/test_squash_ctrl.sv
`timescale 1ns/1ps
module test_squash_ctrl;
    localparam int NT  = 2;
    localparam int SW  = 16;
    localparam int PW  = 32;
    localparam int LAT = 4;
    localparam int CW  = 16;

    logic                 clk = 1'b0;
    logic                 rst_n;
    logic [NT-1:0]        ex_sq_valid, ex_sq_incl, ex_sq_mispred, ex_sq_taken;
    logic [NT-1:0][SW-1:0] ex_sq_seq, rob_head_seq, ins_seq;
    logic [NT-1:0][PW-1:0] ex_sq_pc, arch_pc;
    logic [NT-1:0]        trap_req, ctx_sq_req, rob_empty, rob_done_sq, ins_valid;
    logic [NT-1:0]        rob_ins_en, rob_sq_valid, fb_squash, fb_rob_sq;
    logic [NT-1:0]        fb_mispred, fb_taken, conflict_err;
    logic [NT-1:0][SW-1:0] rob_sq_seq, fb_done_seq;
    logic [NT-1:0][PW-1:0] fb_next_pc;
    logic [NT-1:0][1:0]   thr_state;
    logic [CW-1:0]        mispred_cnt;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    squash_ctrl #(.N_THR(NT), .SEQ_W(SW), .PC_W(PW), .TRAP_LAT(LAT), .CNT_W(CW)) i_squash_ctrl (
        .clk(clk), .rst_n(rst_n),
        .ex_sq_valid(ex_sq_valid), .ex_sq_seq(ex_sq_seq), .ex_sq_incl(ex_sq_incl),
        .ex_sq_pc(ex_sq_pc), .ex_sq_mispred(ex_sq_mispred), .ex_sq_taken(ex_sq_taken),
        .trap_req(trap_req), .ctx_sq_req(ctx_sq_req), .arch_pc(arch_pc),
        .rob_empty(rob_empty), .rob_head_seq(rob_head_seq), .rob_done_sq(rob_done_sq),
        .ins_valid(ins_valid), .ins_seq(ins_seq), .rob_ins_en(rob_ins_en),
        .rob_sq_valid(rob_sq_valid), .rob_sq_seq(rob_sq_seq), .fb_squash(fb_squash),
        .fb_rob_sq(fb_rob_sq), .fb_done_seq(fb_done_seq), .fb_mispred(fb_mispred),
        .fb_taken(fb_taken), .fb_next_pc(fb_next_pc), .thr_state(thr_state),
        .conflict_err(conflict_err), .mispred_cnt(mispred_cnt)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle();
        ex_sq_valid = '0; ex_sq_incl = '0; ex_sq_mispred = '0; ex_sq_taken = '0;
        ex_sq_seq = '0; ex_sq_pc = '0; trap_req = '0; ctx_sq_req = '0;
        rob_done_sq = '0; ins_valid = '0; ins_seq = '0;
    endtask

    task automatic redirect(input int t, input logic [SW-1:0] seq, input logic incl,
                            input logic [PW-1:0] pc, input logic mis, input logic tkn);
        ex_sq_valid[t] = 1'b1; ex_sq_seq[t] = seq; ex_sq_incl[t] = incl;
        ex_sq_pc[t] = pc; ex_sq_mispred[t] = mis; ex_sq_taken[t] = tkn;
    endtask

    task automatic finish_walk();
        rob_done_sq = '1;
        tick();
        idle();
    endtask

    task automatic t_reset();
        chk("R1 state", 64'(thr_state), 64'd0);
        chk("R1 squash", 64'(fb_squash | rob_sq_valid | fb_rob_sq), 64'd0);
        chk("R1 count", 64'(mispred_cnt), 64'd0);
    endtask

    task automatic t_exec_basic();
        ins_valid[0] = 1'b1; ins_seq[0] = 16'd10;
        #1 chk("R6 insert accepted", 64'(rob_ins_en[0]), 64'd1);
        tick(); idle();
        redirect(0, 16'd12, 1'b0, 32'h100, 1'b1, 1'b1);
        tick(); idle();
        chk("R3 younger redirect ignored", 64'(fb_squash), 64'd0);
        chk("R3 state kept", 64'(thr_state[0]), 64'd0);
        redirect(0, 16'd8, 1'b0, 32'h100, 1'b1, 1'b1);
        tick(); idle();
        chk("R2 squash", 64'(fb_squash), 64'b01);
        chk("R2 cmd", 64'(rob_sq_valid), 64'b01);
        chk("R2 cmd seq", 64'(rob_sq_seq[0]), 64'd8);
        chk("R2 done seq", 64'(fb_done_seq[0]), 64'd8);
        chk("R2 pc", 64'(fb_next_pc[0]), 64'h100);
        chk("R2 mispred", 64'(fb_mispred), 64'b01);
        chk("R2 taken", 64'(fb_taken), 64'b01);
        chk("R2 robsq", 64'(fb_rob_sq), 64'b01);
        chk("R2 state", 64'(thr_state[0]), 64'd2);
        chk("R11 other thread", 64'(thr_state[1]), 64'd0);
        chk("R10 count", 64'(mispred_cnt), 64'd1);
        tick();
        chk("R12 squash one cycle", 64'(fb_squash), 64'd0);
        chk("R12 pc cleared", 64'(fb_next_pc[0]), 64'd0);
        chk("R5 robsq held", 64'(fb_rob_sq[0]), 64'd1);
        chk("R5 still squashing", 64'(thr_state[0]), 64'd2);
        ins_valid[0] = 1'b1; ins_seq[0] = 16'd9;
        #1 chk("R6 insert refused", 64'(rob_ins_en[0]), 64'd0);
        tick(); idle();
        rob_done_sq[0] = 1'b1; ins_valid[0] = 1'b1; ins_seq[0] = 16'd9;
        #1 chk("R6 insert on done", 64'(rob_ins_en[0]), 64'd1);
        tick(); idle();
        chk("R5 back to run", 64'(thr_state[0]), 64'd0);
        chk("R5 robsq dropped", 64'(fb_rob_sq[0]), 64'd0);
    endtask

    task automatic t_include_self();
        redirect(0, 16'd9, 1'b1, 32'h140, 1'b0, 1'b0);
        tick(); idle();
        chk("R4 target minus one", 64'(rob_sq_seq[0]), 64'd8);
        chk("R4 squash", 64'(fb_squash[0]), 64'd1);
        chk("R10 no mispred no count", 64'(mispred_cnt), 64'd1);
        redirect(0, 16'd9, 1'b0, 32'h180, 1'b0, 1'b0);
        tick(); idle();
        chk("R4 youngest is target", 64'(fb_squash[0]), 64'd0);
        redirect(0, 16'd8, 1'b0, 32'h180, 1'b0, 1'b0);
        tick(); idle();
        chk("R4 equal accepted", 64'(fb_squash[0]), 64'd1);
        chk("R4 equal seq", 64'(fb_done_seq[0]), 64'd8);
        finish_walk();
    endtask

    task automatic t_trap();
        rob_empty[1] = 1'b0; rob_head_seq[1] = 16'd15; arch_pc[1] = 32'h2000;
        ins_valid[1] = 1'b1; ins_seq[1] = 16'd20;
        tick(); idle();
        trap_req[1] = 1'b1;
        tick(); idle();
        chk("R7 trap wait", 64'(thr_state[1]), 64'd1);
        redirect(1, 16'd5, 1'b0, 32'h500, 1'b1, 1'b0);
        tick(); idle();
        chk("R7 redirect ignored", 64'(fb_squash[1]), 64'd0);
        chk("R7 count unchanged", 64'(mispred_cnt), 64'd1);
        for (int k = 2; k < LAT + 1; k++) begin
            tick();
            chk("R7 not early", 64'(fb_squash[1]), 64'd0);
        end
        redirect(1, 16'd5, 1'b0, 32'h500, 1'b1, 1'b1);
        tick(); idle();
        chk("R7 trap squash", 64'(fb_squash[1]), 64'd1);
        chk("R8 head minus one", 64'(rob_sq_seq[1]), 64'd14);
        chk("R8 restart pc", 64'(fb_next_pc[1]), 64'h2000);
        chk("R8 mispred clear", 64'(fb_mispred[1]), 64'd0);
        chk("R8 taken clear", 64'(fb_taken[1]), 64'd0);
        chk("R8 state", 64'(thr_state[1]), 64'd2);
        chk("R10 count after trap", 64'(mispred_cnt), 64'd1);
        redirect(1, 16'd1, 1'b0, 32'h600, 1'b0, 1'b0);
        tick(); idle();
        chk("R8 youngest zero", 64'(fb_squash[1]), 64'd0);
        finish_walk();
    endtask

    task automatic t_ctx_empty();
        rob_empty[1] = 1'b1; arch_pc[1] = 32'h3000;
        ctx_sq_req[1] = 1'b1;
        redirect(1, 16'd0, 1'b0, 32'h700, 1'b1, 1'b0);
        tick(); idle();
        chk("R8 ctx squash", 64'(fb_squash[1]), 64'd1);
        chk("R8 empty target", 64'(rob_sq_seq[1]), 64'd0);
        chk("R8 ctx pc", 64'(fb_next_pc[1]), 64'h3000);
        chk("R8 ctx beats redirect", 64'(fb_mispred[1]), 64'd0);
        chk("R9 no conflict", 64'(conflict_err), 64'd0);
        finish_walk();
        rob_empty[1] = 1'b0;
    endtask

    task automatic t_conflict();
        rob_head_seq[1] = 16'd40; arch_pc[1] = 32'h4000;
        trap_req[1] = 1'b1;
        tick(); idle();
        for (int k = 0; k < LAT; k++) tick();
        ctx_sq_req[1] = 1'b1;
        tick(); idle();
        chk("R9 conflict flag", 64'(conflict_err), 64'b10);
        chk("R9 trap squash", 64'(fb_squash[1]), 64'd1);
        chk("R9 trap target", 64'(rob_sq_seq[1]), 64'd39);
        tick();
        chk("R9 single squash", 64'(fb_squash[1]), 64'd0);
        chk("R9 flag one cycle", 64'(conflict_err), 64'd0);
        finish_walk();
    endtask

    task automatic t_dual_mispred();
        redirect(0, 16'd0, 1'b0, 32'h800, 1'b1, 1'b0);
        redirect(1, 16'd0, 1'b0, 32'h900, 1'b1, 1'b0);
        tick(); idle();
        chk("R10 both squash", 64'(fb_squash), 64'b11);
        chk("R10 count plus two", 64'(mispred_cnt), 64'd3);
        chk("R11 pc t0", 64'(fb_next_pc[0]), 64'h800);
        chk("R11 pc t1", 64'(fb_next_pc[1]), 64'h900);
        finish_walk();
        chk("R5 both run", 64'(thr_state), 64'd0);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        idle();
        rob_empty = '0; rob_head_seq = '0; arch_pc = '0;
        rst_n = 1'b0;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        t_reset();
        t_exec_basic();
        t_include_self();
        t_trap();
        t_ctx_empty();
        t_conflict();
        t_dual_mispred();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule